// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the general-purpose registers of a 32-bit processor core that has seven operating modes. A register index does not always select the same storage. Some indices are backed by a separate physical copy for each mode, so the value seen depends on the mode the core is in. The fast-interrupt mode has its own copies of indices 8 to 14. The four other exception modes (normal interrupt, supervisor, abort, undefined) have their own copies of only the stack pointer (index 13) and the link register (index 14). Indices 0 to 7 and the program counter (index 15) always resolve to a single shared copy.

The block has two combinational read ports and one write port that commits on the clock edge. A single 5-bit mode input and a user-bank override apply to all three ports. When the override is high, indices 8 to 14 resolve to the user copies, so privileged code can save or restore user state. The block also keeps one saved-status word for each exception mode. That word is read and written through a separate port keyed by the current mode. The register array has no reset, so it can map onto distributed or block RAM. Only the saved-status words are cleared by the synchronous active-high reset.

Top module: `rbank_regfile`

## Requirements
- R1: Mode encodings are 5'b10000 user, 5'b10001 fast-interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined and 5'b11111 system. Any other value selects the user bank for every port.
- R2: System mode reads and writes the same physical registers as user mode for every index.
- R3: In fast-interrupt mode, indices 8–14 address private copies. Writing them leaves the user copies of those indices unchanged, and indices 0–7 in that mode are the user copies.
- R4: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 address a private pair for each mode. Indices 0–12 are the user copies.
- R5: Index 15 addresses one register shared by all modes. A value written in any mode is read back in every other mode.
- R6: Each of the five exception modes has its own saved-status word, read on `sr_rd_data` and written with `sr_wr_en`. All five words read zero after reset.
- R7: In user, system or any unlisted mode, `sr_rd_data` is zero and `sr_wr_en` changes no saved-status word.
- R8: While `force_user` is high, indices 8–14 on all three ports resolve to the user bank whatever the mode.
- R9: A write commits at the rising clock edge. A read of the written register in the same cycle returns the old value, and a read in the next cycle returns the new value.
- R10: The two read ports are independent. When both give the same index they return the same value, and when they give different indices each returns its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the saved-status words and blocks writes |
| mode | input | 5 | Current operating mode encoding |
| force_user | input | 1 | Resolve indices 8–14 to the user bank on all ports |
| ra_idx | input | 4 | Read port A register index |
| ra_data | output | DATA_W | Read port A data (combinational) |
| rb_idx | input | 4 | Read port B register index |
| rb_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | DATA_W | Write data |
| sr_wr_en | input | 1 | Saved-status write enable for the current mode |
| sr_wr_data | input | PSR_W | Saved-status write data |
| sr_rd_data | output | PSR_W | Saved-status word of the current mode, zero outside exception modes |

## Verification
The bench builds the block with DATA_W and PSR_W both set to 32. With that width it can give every physical copy a distinct value: a per-mode prefix in the upper byte and the index in the low bits. A wrong bank, a swapped stack/link pair or a leak between the fast-interrupt bank and the user copies then shows up as a wrong prefix or a wrong low nibble. Because the array has no reset, the bench fills every slot before any register read. That makes the shared, private, override and same-cycle read cases observable against known contents.

// File: rtl/rbank_pkg.sv
`timescale 1ns/1ps
package rbank_pkg;

  localparam int IDX_W  = 4;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // bank order: pair banks follow the fast-interrupt bank contiguously
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int N_EXC = 5;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BK_FIQ;
      M_IRQ:   return BK_IRQ;
      M_SVC:   return BK_SVC;
      M_ABT:   return BK_ABT;
      M_UND:   return BK_UND;
      default: return BK_USR;  // user, system and unlisted codes
    endcase
  endfunction

  function automatic logic is_exc(input logic [MODE_W-1:0] m);
    return mode_to_bank(m) != BK_USR;
  endfunction

endpackage

// File: rtl/rbank_map.sv
`timescale 1ns/1ps
module rbank_map
  import rbank_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int FIQ_LO   = 8,
  parameter int PAIR_LO  = 13,
  parameter int SHARE_HI = 14,
  parameter int SLOT_W   = 5
) (
  input  bank_e             bank,
  input  logic              force_user,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot
);

  localparam int FIQ_CNT   = SHARE_HI - FIQ_LO + 1;
  localparam int PAIR_CNT  = SHARE_HI - PAIR_LO + 1;
  localparam int FIQ_BASE  = NREG;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;

  bank_e eff;
  int    i;
  int    s;

  always_comb begin
    eff = force_user ? BK_USR : bank;
    i   = int'(idx);
    s   = i;
    if (eff == BK_FIQ && i >= FIQ_LO && i <= SHARE_HI)
      s = FIQ_BASE + (i - FIQ_LO);
    else if (eff != BK_USR && eff != BK_FIQ && i >= PAIR_LO && i <= SHARE_HI)
      s = PAIR_BASE + PAIR_CNT * (int'(eff) - int'(BK_IRQ)) + (i - PAIR_LO);
    slot = s[SLOT_W-1:0];
  end

endmodule

// File: rtl/rbank_store.sv
`timescale 1ns/1ps
module rbank_store #(
  parameter int DATA_W = 32,
  parameter int NSLOT  = 31,
  parameter int SLOT_W = 5,
  parameter int NRD    = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [SLOT_W-1:0]     wa,
  input  logic [DATA_W-1:0]     wd,
  input  logic [NRD*SLOT_W-1:0] ra,
  output logic [NRD*DATA_W-1:0] rd
);

  logic [DATA_W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (we && int'(wa) < NSLOT) mem[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [SLOT_W-1:0] a;
    assign a = ra[p*SLOT_W +: SLOT_W];
    assign rd[p*DATA_W +: DATA_W] = (int'(a) < NSLOT) ? mem[a] : '0;
  end

endmodule

// File: rtl/rbank_spsr.sv
`timescale 1ns/1ps
module rbank_spsr
  import rbank_pkg::*;
#(
  parameter int PSR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  bank_e            bank,
  input  logic             we,
  input  logic [PSR_W-1:0] wd,
  output logic [PSR_W-1:0] rd
);

  logic [PSR_W-1:0] sr [N_EXC];
  logic             hit;
  int               sel;

  assign hit = (bank != BK_USR);
  assign sel = hit ? int'(bank) - 1 : 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_EXC; k++) sr[k] <= '0;
    end else if (we && hit) begin
      sr[sel] <= wd;
    end
  end

  assign rd = hit ? sr[sel] : '0;

endmodule

// File: rtl/rbank_regfile.sv
`timescale 1ns/1ps
module rbank_regfile
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode,
  input  logic              force_user,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr_en,
  input  logic [PSR_W-1:0]  sr_wr_data,
  output logic [PSR_W-1:0]  sr_rd_data
);

  localparam int NREG     = 1 << IDX_W;
  localparam int FIQ_LO   = 8;
  localparam int PAIR_LO  = 13;
  localparam int SHARE_HI = 14;
  localparam int NPAIR    = N_EXC - 1;
  localparam int NSLOT    = NREG + (SHARE_HI - FIQ_LO + 1) + NPAIR * (SHARE_HI - PAIR_LO + 1);
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int NPORT    = 3;  // port 0: read A, 1: read B, 2: write

  bank_e                   bank;
  logic [IDX_W-1:0]        idx  [NPORT];
  logic [SLOT_W-1:0]       slot [NPORT];
  logic [2*SLOT_W-1:0]     rd_addr;
  logic [2*DATA_W-1:0]     rd_bus;

  assign bank   = mode_to_bank(mode);
  assign idx[0] = ra_idx;
  assign idx[1] = rb_idx;
  assign idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rbank_map #(
      .NREG(NREG), .FIQ_LO(FIQ_LO), .PAIR_LO(PAIR_LO),
      .SHARE_HI(SHARE_HI), .SLOT_W(SLOT_W)
    ) u_map (
      .bank(bank), .force_user(force_user), .idx(idx[p]), .slot(slot[p])
    );
  end

  assign rd_addr = {slot[1], slot[0]};

  rbank_store #(
    .DATA_W(DATA_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .NRD(2)
  ) u_store (
    .clk(clk), .we(wr_en && !rst), .wa(slot[2]), .wd(wr_data),
    .ra(rd_addr), .rd(rd_bus)
  );

  assign ra_data = rd_bus[0 +: DATA_W];
  assign rb_data = rd_bus[DATA_W +: DATA_W];

  rbank_spsr #(.PSR_W(PSR_W)) u_spsr (
    .clk(clk), .rst(rst), .bank(bank), .we(sr_wr_en),
    .wd(sr_wr_data), .rd(sr_rd_data)
  );

endmodule

// File: rtl/rbank_chk.sv
`timescale 1ns/1ps
module rbank_chk
  import rbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSR_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        mode,
  input logic              force_user,
  input logic [3:0]        ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [3:0]        rb_idx,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sr_wr_en,
  input logic [PSR_W-1:0]  sr_wr_data,
  input logic [PSR_W-1:0]  sr_rd_data
);

  assert_sr_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !is_exc(mode) |-> sr_rd_data == '0);

  assert_sr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(sr_wr_en && is_exc(mode) && !rst) && mode == $past(mode))
      |-> sr_rd_data == $past(sr_wr_data));

  assert_write_next_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !rst) && ra_idx == $past(wr_idx) && mode == $past(mode)
      && force_user == $past(force_user))
      |-> ra_data == $past(wr_data));

  assert_pc_shared_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !rst && wr_idx == 4'd15) && ra_idx == 4'd15)
      |-> ra_data == $past(wr_data));

  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == rb_idx) |-> ra_data == rb_data);

endmodule

bind rbank_regfile rbank_chk #(.DATA_W(DATA_W), .PSR_W(PSR_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .force_user(force_user),
  .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data)
);

// File: tb/sim_rbank_regfile.sv
`timescale 1ns/1ps
module sim_rbank_regfile;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10100;

  logic        clk = 0, rst = 1;
  logic [4:0]  mode = USR;
  logic        force_user = 0;
  logic [3:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0;
  logic        wr_en = 0, sr_wr_en = 0;
  logic [31:0] sr_wr_data = 0, sr_rd_data;

  always #2 clk = ~clk;

  rbank_regfile u0 (.*);

  typedef struct { int port; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // monitor: compares queued expectations shortly after each driving edge
  always begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.port == 0) ? ra_data : (it.port == 1) ? rb_data : sr_rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s port%0d actual=%h expected=%h", it.req, it.port, act, it.exp);
      end
    end
  end

  task automatic idle();
    wr_en = 0; sr_wr_en = 0;
  endtask

  task automatic wr(input logic [4:0] m, input logic fu, input int i, input logic [31:0] d);
    @(negedge clk);
    idle(); mode = m; force_user = fu; wr_en = 1; wr_idx = 4'(i); wr_data = d;
  endtask

  task automatic rd(input logic [4:0] m, input logic fu, input int a, input logic [31:0] ea,
                    input int b, input logic [31:0] eb, input string req);
    @(negedge clk);
    idle(); mode = m; force_user = fu; ra_idx = 4'(a); rb_idx = 4'(b);
    q.push_back('{0, ea, req});
    q.push_back('{1, eb, req});
  endtask

  task automatic srw(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    idle(); mode = m; force_user = 0; sr_wr_en = 1; sr_wr_data = d;
  endtask

  task automatic srr(input logic [4:0] m, input logic [31:0] e, input string req);
    @(negedge clk);
    idle(); mode = m; force_user = 0;
    q.push_back('{2, e, req});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R6: reset state of saved-status words, R7 user reads zero
    srr(FIQ, 0, "R6"); srr(IRQ, 0, "R6"); srr(SVC, 0, "R6");
    srr(ABT, 0, "R6"); srr(UND, 0, "R6"); srr(USR, 0, "R7");

    for (int i = 0; i < 16; i++) wr(USR, 0, i, 32'h1000_0000 + 32'(i));
    for (int i = 8; i < 15; i++) wr(FIQ, 0, i, 32'hF000_0000 + 32'(i));
    for (int i = 13; i < 15; i++) begin
      wr(IRQ, 0, i, 32'hA000_0000 + 32'(i));
      wr(SVC, 0, i, 32'hB000_0000 + 32'(i));
      wr(ABT, 0, i, 32'hC000_0000 + 32'(i));
      wr(UND, 0, i, 32'hD000_0000 + 32'(i));
    end

    // R3: private fast-interrupt bank, user copies untouched
    rd(USR, 0, 8, 32'h1000_0008, 14, 32'h1000_000E, "R3");
    rd(FIQ, 0, 8, 32'hF000_0008, 14, 32'hF000_000E, "R3");
    rd(FIQ, 0, 7, 32'h1000_0007, 12, 32'hF000_000C, "R3");
    // R4: stack/link pairs per mode, lower indices shared
    rd(IRQ, 0, 13, 32'hA000_000D, 14, 32'hA000_000E, "R4");
    rd(SVC, 0, 13, 32'hB000_000D, 14, 32'hB000_000E, "R4");
    rd(ABT, 0, 14, 32'hC000_000E, 12, 32'h1000_000C, "R4");
    rd(UND, 0, 13, 32'hD000_000D, 8, 32'h1000_0008, "R4");
    // R2: system equals user
    rd(SYS, 0, 13, 32'h1000_000D, 9, 32'h1000_0009, "R2");
    // R1: unlisted mode code behaves as user
    rd(BAD, 0, 13, 32'h1000_000D, 10, 32'h1000_000A, "R1");
    // R5: program counter shared
    rd(FIQ, 0, 15, 32'h1000_000F, 15, 32'h1000_000F, "R5");
    wr(SVC, 0, 15, 32'h0000_5555);
    rd(USR, 0, 15, 32'h0000_5555, 0, 32'h1000_0000, "R5");
    rd(UND, 0, 15, 32'h0000_5555, 3, 32'h1000_0003, "R5");
    // R8: user-bank override
    rd(FIQ, 1, 8, 32'h1000_0008, 3, 32'h1000_0003, "R8");
    rd(IRQ, 1, 14, 32'h1000_000E, 13, 32'h1000_000D, "R8");
    wr(SVC, 1, 13, 32'h0000_7777);
    rd(SYS, 0, 13, 32'h0000_7777, 14, 32'h1000_000E, "R8");
    rd(SVC, 0, 13, 32'hB000_000D, 14, 32'hB000_000E, "R8");
    // R9: same-cycle read returns old value, next cycle new
    @(negedge clk);
    idle(); mode = USR; force_user = 0; ra_idx = 2; rb_idx = 2;
    wr_en = 1; wr_idx = 2; wr_data = 32'hDEAD_BEEF;
    q.push_back('{0, 32'h1000_0002, "R9"});
    q.push_back('{1, 32'h1000_0002, "R9"});
    rd(USR, 0, 2, 32'hDEAD_BEEF, 5, 32'h1000_0005, "R9");
    // R10: independent ports
    rd(IRQ, 0, 0, 32'h1000_0000, 13, 32'hA000_000D, "R10");
    rd(FIQ, 0, 11, 32'hF000_000B, 11, 32'hF000_000B, "R10");
    // R6: saved-status per exception mode
    srw(FIQ, 32'h11); srw(IRQ, 32'h22); srw(SVC, 32'h33);
    srw(ABT, 32'h44); srw(UND, 32'h55);
    srr(FIQ, 32'h11, "R6"); srr(IRQ, 32'h22, "R6"); srr(SVC, 32'h33, "R6");
    srr(ABT, 32'h44, "R6"); srr(UND, 32'h55, "R6");
    // R7: writes outside exception modes ignored
    srw(USR, 32'h99); srw(SYS, 32'h98); srw(BAD, 32'h97);
    srr(USR, 0, "R7"); srr(SYS, 0, "R7"); srr(BAD, 0, "R7");
    srr(FIQ, 32'h11, "R7"); srr(UND, 32'h55, "R7");

    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule